// File: doc/BRIEF.md
# Oversampling UART Receive Data Recovery

This block turns an asynchronous serial line into data words. The line is first passed through a two-flop synchronizer. It is then sampled once per pulse of an external oversampling enable, so the pulse rate sets the baud rate and no divider sits inside the block. A speed-mode input selects either 16 samples per bit or 8 samples per bit. The mode is captured when a frame's start edge is seen and holds for the whole of that frame.

Each bit is decided by a two-out-of-three majority over the three samples around the bit's centre. This filters short spikes on the line. The start bit is voted as well: a start whose centre votes high is treated as noise, and the receiver drops back to idle without producing a word. After the data bits, only the first stop bit is voted. A low vote on it marks the frame as broken. The receiver re-arms as soon as the last stop-bit vote sample has been taken, so a sender running slightly fast can begin its next start bit before the stop bit would nominally end.

Results come out as a one-clock valid pulse. The word and the error flag are presented with the pulse and hold until the next frame finishes.

Top module: `uart_rx_recover`

## Requirements
- R1: While rst_n is low, and after its release until the first frame completes, valid_o is 0, frame_err_o is 0 and data_o is all zeros.
- R2: The line is sampled only on clocks where os_tick_i is 1. With os_tick_i held at 0, no activity on rxd_i produces a frame. rxd_i reaches the sampler through two flops.
- R3: A frame begins on a sample that is 0 when the previous sample was 1. If the start bit's centre vote gives 1, no frame is reported and the receiver returns to idle.
- R4: With dbl_speed_i = 0, a bit spans 16 samples, numbered 1 to 16 from the bit's first sample. Its value is 1 when at least two of samples 8, 9 and 10 are 1. The other samples have no effect.
- R5: With dbl_speed_i = 1 at the start edge, a bit spans 8 samples and the vote uses samples 4, 5 and 6. The mode is captured at the start edge.
- R6: DATA_W data bits (5 to 9, default 8) follow the start bit, least significant first. The first data bit received appears on data_o[0].
- R7: valid_o is high for exactly one clock, the clock after the tick that carries the stop bit's last vote sample. data_o and frame_err_o change only with that pulse and hold until the next one.
- R8: frame_err_o is 1 exactly when the first stop bit votes 0. Nothing on the line after that stop bit's vote samples is examined for the frame.
- R9: A start edge on the sample right after the stop bit's last vote sample (sample 11 at 16 per bit, sample 7 at 8 per bit) is accepted as the next frame's start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| os_tick_i | input | 1 | Oversampling enable, one pulse per sample |
| dbl_speed_i | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| data_o | output | DATA_W | Last received word |
| valid_o | output | 1 | One-clock pulse when a frame completes |
| frame_err_o | output | 1 | Stop bit of the last frame voted low |

## Verification
A wrong sample counter or a misplaced vote window shows as a bad bit in the word of the frame being received. This becomes visible at the valid pulse that ends the frame, or as a missing or extra pulse once the count drifts by a whole bit. A stuck receiver state shows as an absent pulse within one frame time. A broken re-arm shows as a lost word in back-to-back frames. The patterns therefore force the vote through its edges: a single corrupted centre sample, two corrupted centre samples, and noise everywhere except the centre. A disagreement on valid_o, data_o or frame_err_o is reported on the clock it occurs.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/rx_sample_timer.sv
module rx_sample_timer #(
  parameter int SAMPLES_NORMAL = 16,
  localparam int CW = $clog2(SAMPLES_NORMAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          busy,
  input  logic          dbl,
  output logic [CW-1:0] cur,
  output logic          vote_a,
  output logic          vote_b,
  output logic          vote_c
);
  localparam logic [CW-1:0] SPB_N = CW'(SAMPLES_NORMAL);
  localparam logic [CW-1:0] SPB_D = CW'(SAMPLES_NORMAL / 2);

  logic [CW-1:0] pos_q, pos_d;
  logic [CW-1:0] spb, vfirst;

  assign spb    = dbl ? SPB_D : SPB_N;
  assign vfirst = spb >> 1;
  assign cur    = (pos_q >= spb) ? CW'(1) : pos_q + CW'(1);
  assign vote_a = (cur == vfirst);
  assign vote_b = (cur == vfirst + CW'(1));
  assign vote_c = (cur == vfirst + CW'(2));

  always_comb begin
    pos_d = pos_q;
    if (start)              pos_d = CW'(1);
    else if (!busy)         pos_d = '0;
    else if (tick)          pos_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R4: the position never passes the normal bit length
  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= SPB_N);
  // R5: in double speed the position stays within 8-sample bits
  assert_dbl_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dbl && !start) |-> pos_q <= SPB_D);
  // R2: without a tick the position does not move mid-frame
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !start) |=> $stable(pos_q));
endmodule

// File: rtl/rx_majority.sv
module rx_majority (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cap_a,
  input  logic cap_b,
  input  logic din,
  output logic vote
);
  logic a_q, b_q, a_d, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (tick && cap_a) a_d = din;
    if (tick && cap_b) b_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign vote = (a_q & b_q) | (a_q & din) | (b_q & din);

  // R4: two agreeing stored samples decide the bit whatever the third is
  assert_pair_decides_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q == b_q) |-> (vote == a_q));
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
  import uart_rx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int SAMPLES_NORMAL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              os_tick_i,
  input  logic              dbl_speed_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int CW = $clog2(SAMPLES_NORMAL + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  initial assert (DATA_W >= 5 && DATA_W <= 9);

  rx_state_e         state_q, state_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] shreg_q, shreg_d, data_q, data_d;
  logic              mode_q, mode_d, prev_q, prev_d;
  logic              valid_q, valid_d, err_q, err_d;

  logic          rxd_s;
  logic          start, busy, vote;
  logic [CW-1:0] cur;
  logic          vote_a, vote_b, vote_c;

  rx_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd_i), .q(rxd_s)
  );

  assign busy  = (state_q != RX_IDLE);
  assign start = os_tick_i && !busy && prev_q && !rxd_s;

  rx_sample_timer #(.SAMPLES_NORMAL(SAMPLES_NORMAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick_i), .start(start), .busy(busy),
    .dbl(mode_q), .cur(cur), .vote_a(vote_a), .vote_b(vote_b), .vote_c(vote_c)
  );

  rx_majority u_vote (
    .clk(clk), .rst_n(rst_n), .tick(os_tick_i && busy), .cap_a(vote_a),
    .cap_b(vote_b), .din(rxd_s), .vote(vote)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    data_d  = data_q;
    mode_d  = mode_q;
    prev_d  = prev_q;
    err_d   = err_q;
    valid_d = 1'b0;
    if (os_tick_i) begin
      prev_d = rxd_s;
      unique case (state_q)
        RX_IDLE: if (start) begin
          state_d = RX_START;
          mode_d  = dbl_speed_i;
        end
        RX_START: if (vote_c) begin
          state_d = vote ? RX_IDLE : RX_DATA;
          bit_d   = '0;
        end
        RX_DATA: if (vote_c) begin
          shreg_d = {vote, shreg_q[DATA_W-1:1]};
          if (bit_q == LAST_BIT) state_d = RX_STOP;
          else                   bit_d   = bit_q + BW'(1);
        end
        RX_STOP: if (vote_c) begin
          state_d = RX_IDLE;
          valid_d = 1'b1;
          err_d   = !vote;
          data_d  = shreg_q;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bit_q   <= '0;
      shreg_q <= '0;
      data_q  <= '0;
      mode_q  <= 1'b0;
      prev_q  <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      data_q  <= data_d;
      mode_q  <= mode_d;
      prev_q  <= prev_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign frame_err_o = err_q;

  // R7: the valid pulse lasts a single clock
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7: the word only moves with a valid pulse
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));
  // R8: the error flag only moves with a valid pulse
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(err_q));
  // R7: a pulse follows only the stop-bit phase
  assert_valid_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(state_q) == RX_STOP);
  // R3: a start bit voted high never reaches the data phase
  assert_glitch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && os_tick_i && vote_c && vote) |=> state_q == RX_IDLE);
endmodule

// File: tb/uart_rx_recover_test.sv
module uart_rx_recover_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int TDIV       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic tick = 1'b0;
  logic tick_en = 1'b1;
  logic dbl = 1'b0;
  logic [W-1:0] data_o;
  logic valid_o, frame_err_o;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int tcnt = 0;

  uart_rx_recover #(.DATA_W(W), .SAMPLES_NORMAL(16)) uut (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .os_tick_i(tick),
    .dbl_speed_i(dbl), .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tick = tick_en && (tcnt == 0);
    tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  end

  // behavioural reference model
  int m_s1, m_s2, m_prev, m_busy, m_pos, m_bit, m_spb, m_cnt, v, vf;
  logic [W-1:0] m_word, m_data;
  logic m_valid, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_busy = 0; m_pos = 0; m_bit = 0;
      m_spb = 16; m_cnt = 0; m_word = '0; m_data = '0; m_valid = 0; m_err = 0;
    end else begin
      v = m_s2; m_s2 = m_s1; m_s1 = int'(rxd); m_valid = 0;
      if (tick) begin
        if (m_busy == 0) begin
          if (m_prev == 1 && v == 0) begin
            m_busy = 1; m_pos = 1; m_bit = 0; m_cnt = 0;
            m_spb = dbl ? 8 : 16;
          end
        end else begin
          m_pos = (m_pos >= m_spb) ? 1 : m_pos + 1;
          vf = m_spb / 2;
          if (m_pos >= vf && m_pos <= vf + 2) m_cnt += v;
          if (m_pos == vf + 2) begin
            if (m_bit == 0) begin
              if (m_cnt >= 2) m_busy = 0;
            end else if (m_bit <= W) begin
              m_word[m_bit-1] = (m_cnt >= 2);
            end else begin
              m_valid = 1; m_err = (m_cnt < 2); m_data = m_word; m_busy = 0;
            end
            m_cnt = 0;
            m_bit++;
          end
        end
        m_prev = v;
      end
    end
  end

  logic [W:0] got_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (valid_o !== m_valid) begin
        fails++;
        $display("FAIL R7 valid_o actual %b expected %b at %0t", valid_o, m_valid, $time);
      end
      if (data_o !== m_data) begin
        fails++;
        $display("FAIL R6 data_o actual %h expected %h at %0t", data_o, m_data, $time);
      end
      if (frame_err_o !== m_err) begin
        fails++;
        $display("FAIL R8 frame_err_o actual %b expected %b at %0t", frame_err_o, m_err, $time);
      end
      if (valid_o) got_q.push_back({frame_err_o, data_o});
    end
  end

  task automatic samp(input logic b);
    rxd = b;
    @(posedge clk);
    while (!tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) samp(1'b1);
  endtask

  task automatic send_pat(input logic [15:0] pat, input int n);
    for (int i = 0; i < n; i++) samp(pat[i]);
  endtask

  // mask flips data-bit samples: mask bit k is sample k+1
  task automatic send_frame(input logic [W-1:0] d, input logic stopv,
                            input int stop_len, input logic [15:0] mask);
    int spb;
    spb = dbl ? 8 : 16;
    send_pat(16'h0000, spb);
    for (int b = 0; b < W; b++) send_pat({16{d[b]}} ^ mask, spb);
    send_pat({16{stopv}}, stop_len);
  endtask

  task automatic expect_frame(input logic [W-1:0] d, input logic e, input string tag);
    logic [W:0] got;
    vectors++;
    if (got_q.size() == 0) begin
      fails++;
      $display("FAIL %s no frame, expected data %h err %b", tag, d, e);
    end else begin
      got = got_q.pop_front();
      if (got !== {e, d}) begin
        fails++;
        $display("FAIL %s actual data %h err %b expected data %h err %b",
                 tag, got[W-1:0], got[W], d, e);
      end
    end
  endtask

  task automatic expect_none(input string tag);
    vectors++;
    if (got_q.size() != 0) begin
      fails++;
      $display("FAIL %s actual %0d frames expected 0", tag, got_q.size());
      got_q.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (valid_o !== 1'b0 || frame_err_o !== 1'b0 || data_o !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b %b %h expected 0 0 00", valid_o, frame_err_o, data_o);
    end
    rst_n = 1'b1;
    idle(20);
    expect_none("R1");

    send_frame(8'hA5, 1'b1, 16, 16'h0000); idle(20);
    expect_frame(8'hA5, 1'b0, "R6");

    send_frame(8'h3C, 1'b1, 16, 16'h0080); idle(20);
    expect_frame(8'h3C, 1'b0, "R4 one centre sample flipped");

    send_frame(8'h5A, 1'b1, 16, 16'hFC7F); idle(20);
    expect_frame(8'h5A, 1'b0, "R4 off-centre samples ignored");

    send_frame(8'h0F, 1'b1, 16, 16'h0180); idle(20);
    expect_frame(8'hF0, 1'b0, "R4 two centre samples decide");

    send_frame(8'h77, 1'b0, 16, 16'h0000); idle(20);
    expect_frame(8'h77, 1'b1, "R8 stop voted low");

    send_frame(8'h12, 1'b1, 10, 16'h0000);
    send_frame(8'h81, 1'b1, 16, 16'h0000); idle(20);
    expect_frame(8'h12, 1'b0, "R9 first of back-to-back");
    expect_frame(8'h81, 1'b0, "R9 early start accepted");

    send_pat(16'h0000, 3); idle(40);
    expect_none("R3 glitch start");

    dbl = 1'b1; idle(4);
    send_frame(8'h96, 1'b1, 6, 16'h0000);
    send_frame(8'h69, 1'b0, 8, 16'h0008); idle(20);
    expect_frame(8'h96, 1'b0, "R5 double speed");
    expect_frame(8'h69, 1'b1, "R5 early start and noise");
    dbl = 1'b0; idle(4);

    tick_en = 1'b0;
    for (int i = 0; i < 400; i++) begin
      rxd = i[3];
      @(negedge clk);
    end
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    tick_en = 1'b1;
    idle(30);
    expect_none("R2 no tick");
    send_frame(8'hC3, 1'b1, 16, 16'h0000); idle(20);
    expect_frame(8'hC3, 1'b0, "R2 resumed sampling");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired at %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule